// File: doc/BRIEF.md
# Constant On-Time PWM Sequencer

This block sequences the two gate enables of one synchronous buck phase under constant on-time, valley-regulated control. It has no switching clock of its own. A high-side pulse of programmed length starts only when three things hold: a minimum off interval has elapsed since the last pulse, the synchronized feedback comparator reports the output at or below the reference, and the valley overcurrent trip is clear. The on-time count arrives precomputed (proportional to Vout/Vin). The block samples it when each pulse starts.

Dead time is adaptive. Neither gate enable rises until the opposite gate's "fully off" sense bit has been seen. If that sense bit does not arrive within a timeout, both gates stay off and a fault is latched. Driving the enable input low clears the fault.

The controller is a six-state machine:
- IDLE: disabled; both gates off.
- LO_GAP: waiting for the high-side-off sense before DL.
- LOW_ON: DL on; the off interval runs here.
- HI_GAP: waiting for the low-side-off sense before DH.
- HIGH_ON: DH on for the on-time.
- FAULT: a dead-time wait timed out.

The transitions are:
- start: IDLE to LO_GAP when enabled.
- hs_clear: LO_GAP to LOW_ON.
- trigger: LOW_ON to HI_GAP.
- ls_clear: HI_GAP to HIGH_ON.
- expire: HIGH_ON to LO_GAP.
- timeout: either gap state to FAULT.
- disable: any state to IDLE.

Top module: `cot_pwm_seq`

## Requirements
- R1: DH stays high for exactly max(ton_cyc, 1) clock cycles. ton_cyc is taken from the cycle before DH rises, and a value of 0 gives a one-cycle pulse.
- R2: A change of ton_cyc while DH is high does not change the length of that pulse.
- R3: Between two pulses, DH stays low for at least MIN_OFF_CYC+1 cycles. With fb_low held high and ls_off/hs_off following the gates one cycle late, that gap is exactly MIN_OFF_CYC+1 cycles.
- R4: Once the off interval has expired, fb_low high with oc_trip low drops DL in the next cycle. DH rises one cycle after ls_off is then seen. While fb_low is low, DL stays high and DH stays low.
- R5: While oc_trip is high, no DH pulse starts and DL stays high. Clearing oc_trip starts the trigger sequence of R4.
- R6: DH rises only if ls_off was high in the previous cycle, and DL rises only if hs_off was high in the previous cycle. DH and DL are never high together.
- R7: en low forces DH and DL low in the same cycle and returns to IDLE. After en rises again, the off interval restarts from zero: with fb_low high, DH rises MIN_OFF_CYC+2 cycles after en is applied.
- R8: If the awaited sense bit stays low for DT_TO_CYC cycles of a gap state, dt_fault rises and both gates stay low. The fault holds until en goes low.
- R9: During and right after reset, DH, DL and dt_fault are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low forces both gates off and clears the fault |
| fb_low | input | 1 | Synchronized feedback at or below reference |
| oc_trip | input | 1 | Valley overcurrent trip |
| ton_cyc | input | TON_W | On-time length in clock cycles |
| ls_off | input | 1 | Low-side gate sensed fully off |
| hs_off | input | 1 | High-side gate sensed fully off |
| dh | output | 1 | High-side gate enable |
| dl | output | 1 | Low-side gate enable |
| dt_fault | output | 1 | Dead-time sense timeout fault |

## Verification
A vector table of on-time values (0, 1, a mid value, and the largest value used) runs back to back with fb_low held high. This separates pulse-width errors from off-interval errors, because each gap must then be exactly the minimum.

Holding fb_low low, then holding oc_trip high, shows that the two blockers hold DL on and DH off. Releasing each one checks the two-cycle trigger latency.

Disabling mid-pulse tests the same-cycle shutdown and the fresh off interval after re-enable. A stuck low-side sense and a stuck high-side sense each check the exact timeout cycle and that the fault holds until en goes low.

// File: rtl/cot_pkg.sv
package cot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LO_GAP  = 3'd1,
        ST_LOW_ON  = 3'd2,
        ST_HI_GAP  = 3'd3,
        ST_HIGH_ON = 3'd4,
        ST_FAULT   = 3'd5
    } cot_state_e;

endpackage

// File: rtl/cot_down_timer.sv
module cot_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/cot_pwm_seq.sv
module cot_pwm_seq
    import cot_pkg::*;
#(
    parameter int TON_W       = 8,
    parameter int MIN_OFF_CYC = 40,
    parameter int DT_TO_CYC   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fb_low,
    input  logic             oc_trip,
    input  logic [TON_W-1:0] ton_cyc,
    input  logic             ls_off,
    input  logic             hs_off,
    output logic             dh,
    output logic             dl,
    output logic             dt_fault
);

    localparam int OFF_W = $clog2(MIN_OFF_CYC + 1);
    localparam int DT_W  = $clog2(DT_TO_CYC + 1);
    localparam logic [OFF_W-1:0] OFF_LOAD = OFF_W'(MIN_OFF_CYC - 1);
    localparam logic [DT_W-1:0]  DT_LOAD  = DT_W'(DT_TO_CYC - 1);

    cot_state_e st, nxt;
    logic load_on, load_off, load_dt;
    logic on_exp, off_exp, dt_exp;
    logic [TON_W-1:0] on_load;

    // a zero count still yields one cycle of high-side drive
    assign on_load = (ton_cyc == '0) ? '0 : ton_cyc - 1'b1;

    cot_down_timer #(.W(TON_W)) u_on_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!en), .load(load_on),
        .load_val(on_load), .expired(on_exp)
    );

    cot_down_timer #(.W(OFF_W)) u_off_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!en), .load(load_off),
        .load_val(OFF_LOAD), .expired(off_exp)
    );

    cot_down_timer #(.W(DT_W)) u_dt_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!en), .load(load_dt),
        .load_val(DT_LOAD), .expired(dt_exp)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state and timer loads
    always_comb begin
        nxt      = st;
        load_on  = 1'b0;
        load_off = 1'b0;
        load_dt  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (en) begin
                    nxt      = ST_LO_GAP;
                    load_off = 1'b1;
                    load_dt  = 1'b1;
                end
            end
            ST_LO_GAP: begin
                if (hs_off)      nxt = ST_LOW_ON;
                else if (dt_exp) nxt = ST_FAULT;
            end
            ST_LOW_ON: begin
                if (off_exp && fb_low && !oc_trip) begin
                    nxt     = ST_HI_GAP;
                    load_dt = 1'b1;
                end
            end
            ST_HI_GAP: begin
                if (ls_off) begin
                    nxt     = ST_HIGH_ON;
                    load_on = 1'b1;
                end else if (dt_exp) begin
                    nxt = ST_FAULT;
                end
            end
            ST_HIGH_ON: begin
                if (on_exp) begin
                    nxt      = ST_LO_GAP;
                    load_off = 1'b1;
                    load_dt  = 1'b1;
                end
            end
            ST_FAULT: nxt = ST_FAULT;
            default:  nxt = ST_IDLE;
        endcase
        if (!en) nxt = ST_IDLE;
    end

    // outputs, gated by enable so shutdown needs no clock edge
    always_comb begin
        dh       = en && (st == ST_HIGH_ON);
        dl       = en && (st == ST_LOW_ON);
        dt_fault = (st == ST_FAULT);
    end

    // checker support: run length of DH low since its last high cycle
    localparam int RUN_W = $clog2(MIN_OFF_CYC + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_OFF_CYC + 1);
    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                low_run <= '0;
        else if (dh)               low_run <= '0;
        else if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
    end

    p_min_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dh) |-> (low_run >= RUN_W'(MIN_OFF_CYC)));

    p_valley_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dl) && en) |-> $past(fb_low));

    p_oc_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dl) && en) |-> $past(!oc_trip));

    p_dh_interlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dh) |-> $past(ls_off));

    p_dl_interlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dl) |-> $past(hs_off));

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dh && dl));

    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!dh && !dl));

    p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_fault && en) |=> dt_fault);

    p_fault_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dt_fault |-> (!dh && !dl));

endmodule

// File: tb/sim_cot_pwm_seq.sv
module sim_cot_pwm_seq;

    localparam int TON_W  = 8;
    localparam int MOFF   = 8;
    localparam int DTO    = 6;
    localparam int NVEC   = 5;
    // {ton_cyc, expected DH width}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'd0,  8'd1}, {8'd1, 8'd1}, {8'd5, 8'd5},
        {8'd17, 8'd17}, {8'd40, 8'd40}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, fb_low = 1'b0, oc_trip = 1'b0;
    logic [TON_W-1:0] ton_cyc = 8'd5;
    logic ls_off = 1'b1, hs_off = 1'b1;
    logic stuck_ls = 1'b0, stuck_hs = 1'b0;
    logic dh, dl, dt_fault;
    int n_chk = 0, n_fail = 0, n_overlap = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cot_pwm_seq #(.TON_W(TON_W), .MIN_OFF_CYC(MOFF), .DT_TO_CYC(DTO)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .fb_low(fb_low), .oc_trip(oc_trip),
        .ton_cyc(ton_cyc), .ls_off(ls_off), .hs_off(hs_off),
        .dh(dh), .dl(dl), .dt_fault(dt_fault)
    );

    // gate-off sense model: follows the gates one cycle late
    always @(negedge clk) begin
        ls_off <= stuck_ls ? 1'b0 : !dl;
        hs_off <= stuck_hs ? 1'b0 : !dh;
        if (dh && dl) n_overlap++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure_high(output int n);
        n = 0;
        while (dh === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure_low(output int n);
        n = 0;
        while (dh !== 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        int w, g, hi;
        repeat (3) @(negedge clk);
        chk(!dh && !dl && !dt_fault, "R9 reset outputs", {dh, dl, dt_fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dh && !dl && !dt_fault, "R9 after reset", {dh, dl, dt_fault}, 0);

        // table of on-time vectors, fb_low held high
        ton_cyc = VEC[0][15:8];
        en = 1'b1;
        fb_low = 1'b1;
        measure_low(g);
        for (int i = 0; i < NVEC; i++) begin
            measure_high(w);
            chk(w == int'(VEC[i][7:0]), "R1 on-time width", w, int'(VEC[i][7:0]));
            if (i < NVEC - 1) ton_cyc = VEC[i+1][15:8];
            measure_low(g);
            chk(g == MOFF + 1, "R3 minimum off gap", g, MOFF + 1);
        end

        // R2: change ton_cyc mid-pulse
        measure_high(w);
        ton_cyc = 8'd20;
        measure_low(g);
        w = 0;
        while (dh === 1'b1 && w < 1000) begin
            w++;
            if (w == 3) ton_cyc = 8'd3;
            @(negedge clk);
        end
        chk(w == 20, "R2 mid-pulse ton change ignored", w, 20);

        // R4: feedback above reference holds off the pulse
        fb_low = 1'b0;
        hi = 0;
        repeat (30) begin
            @(negedge clk);
            if (dh) hi++;
        end
        chk(hi == 0, "R4 no pulse while fb high", hi, 0);
        chk(dl == 1'b1, "R4 DL held on while waiting", dl, 1);
        fb_low = 1'b1;
        @(negedge clk);
        chk(!dl && !dh, "R4/R6 DL off before DH", {dh, dl}, 0);
        @(negedge clk);
        chk(dh == 1'b1, "R4 DH rises after trigger", dh, 1);
        measure_high(w);
        chk(w == 3, "R1 width after trigger", w, 3);

        // R5: overcurrent blocks pulses
        oc_trip = 1'b1;
        hi = 0;
        repeat (30) begin
            @(negedge clk);
            if (dh) hi++;
        end
        chk(hi == 0, "R5 no pulse during overcurrent", hi, 0);
        chk(dl == 1'b1, "R5 DL held on during overcurrent", dl, 1);
        oc_trip = 1'b0;
        @(negedge clk);
        chk(!dl && !dh, "R5 DL off after release", {dh, dl}, 0);
        @(negedge clk);
        chk(dh == 1'b1, "R5 DH rises after release", dh, 1);
        measure_high(w);

        // R7: disable mid-pulse
        measure_low(g);
        en = 1'b0;
        #1;
        chk(!dh && !dl, "R7 same-cycle shutdown", {dh, dl}, 0);
        repeat (5) @(negedge clk);
        chk(!dh && !dl && !dt_fault, "R7 held off while disabled", {dh, dl, dt_fault}, 0);
        ton_cyc = 8'd6;
        en = 1'b1;
        measure_low(g);
        chk(g == MOFF + 2, "R7 fresh off interval after enable", g, MOFF + 2);
        measure_high(w);
        chk(w == 6, "R7 pulse after re-enable", w, 6);

        // R8: low-side sense stuck
        stuck_ls = 1'b1;
        g = 0;
        while (dl !== 1'b1 && g < 1000) begin g++; @(negedge clk); end
        while (dl === 1'b1 && g < 2000) begin g++; @(negedge clk); end
        w = 0;
        while (dt_fault !== 1'b1 && w < 1000) begin
            w++;
            @(negedge clk);
        end
        chk(w == DTO, "R8 low-side timeout cycle", w, DTO);
        chk(!dh && !dl, "R8 gates off in fault", {dh, dl}, 0);
        stuck_ls = 1'b0;
        repeat (10) @(negedge clk);
        chk(dt_fault && !dh && !dl, "R8 fault holds", {dh, dl, dt_fault}, 1);
        en = 1'b0;
        @(negedge clk);
        chk(dt_fault == 1'b0, "R8 fault cleared by disable", dt_fault, 0);
        en = 1'b1;

        // R8: high-side sense stuck
        measure_low(g);
        stuck_hs = 1'b1;
        measure_high(w);
        w = 0;
        hi = 0;
        while (dt_fault !== 1'b1 && w < 1000) begin
            w++;
            if (dl) hi++;
            @(negedge clk);
        end
        chk(w == DTO, "R8 high-side timeout cycle", w, DTO);
        chk(hi == 0 && !dl, "R6/R8 DL never on without hs_off", hi, 0);
        en = 1'b0;
        stuck_hs = 1'b0;
        @(negedge clk);
        chk(n_overlap == 0, "R6 DH and DL never overlap", n_overlap, 0);

        done = 1'b1;
        summary();
    end

endmodule